// File: doc/BRIEF.md
# Load-Store Address and Data Unit

This unit sits between a core's register file and a synchronous data memory port. For each request it takes a base register value, an unsigned offset magnitude with an add/subtract control, an indexing mode, a transfer size and a sign-extension flag. In the same cycle it presents the memory address, the lane enables and the steered store data. It also presents the updated base value and an enable that says whether that value goes back to the base register.

The memory returns read data one cycle after a read request. The unit registers the lane position, the size and the extension flag of every load. In the following cycle it picks the addressed byte, halfword or word out of the returned beat, widens it to 32 bits and raises a load-valid strobe. Base write-back and load data leave on separate ports, so the register file can retire both results of a post-indexed or write-back load.

Byte lanes are little-endian. Lane n carries bits 8n+7 down to 8n of the memory beat.

Top module: `ldst_agu`

## Requirements
- R1: Index mode 2'b00 (pre-index, no write-back) drives mem_addr = base_val ± offset_val and keeps wb_en low. The unused encoding 2'b11 behaves exactly like 2'b00.
- R2: Index mode 2'b01 (pre-index with write-back) drives mem_addr = base_val ± offset_val, raises wb_en and gives wb_value equal to that same address.
- R3: Index mode 2'b10 (post-index) drives mem_addr = base_val unmodified, raises wb_en and gives wb_value = base_val ± offset_val.
- R4: offset_up = 1 adds the zero-extended offset and offset_up = 0 subtracts it, modulo 2^ADDR_W (for example, 0x2 minus 4 gives 0xFFFFFFFE).
- R5: A byte transfer (xfer_size 2'b00) enables only lane mem_addr[1:0]. A byte store copies store_data[7:0] onto every lane.
- R6: A halfword transfer (xfer_size 2'b01) enables lanes 1:0 when mem_addr[1] = 0 and lanes 3:2 when it is 1. A halfword store copies store_data[15:0] onto both halves.
- R7: A word transfer (xfer_size 2'b10, and the unused 2'b11) enables all four lanes and drives store_data unchanged on mem_wdata.
- R8: A byte load returns, one cycle after the request, the byte at lane mem_addr[1:0]. It is sign-extended to 32 bits when load_signed = 1 and zero-extended otherwise.
- R9: A halfword load returns, one cycle after the request, the half selected by mem_addr[1], sign- or zero-extended by load_signed.
- R10: A word load returns the full read word one cycle after the request, whatever load_signed is.
- R11: mem_req follows req_valid and mem_we is high only for a valid store. wb_en is never high without req_valid. ld_valid is high exactly in the cycle after a valid load request.
- R12: While rst_n is low and after reset until the first load, ld_valid is low and ld_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A transfer is requested this cycle |
| req_load | input | 1 | 1 = load, 0 = store |
| idx_mode | input | 2 | 00 pre, 01 pre with write-back, 10 post, 11 as 00 |
| offset_up | input | 1 | 1 = add offset, 0 = subtract offset |
| xfer_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| load_signed | input | 1 | Sign-extend byte/halfword loads |
| base_val | input | ADDR_W | Base register value |
| offset_val | input | OFF_W | Offset magnitude |
| store_data | input | 32 | Register value to store |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_be | output | DATA_W/8 | Lane enables |
| mem_wdata | output | DATA_W | Lane-steered store data |
| mem_rdata | input | DATA_W | Read beat, valid one cycle after a read |
| wb_en | output | 1 | Write wb_value back to the base register |
| wb_value | output | ADDR_W | Updated base value |
| ld_valid | output | 1 | ld_data holds a finished load |
| ld_data | output | 32 | Extended load result |

## Verification
The bench builds the unit with a 32-bit address, a 32-bit memory beat (four lanes) and a 12-bit offset. With these values every lane position and both halfword positions can be reached through mem_addr[1:0]. The offsets 4 and 16 fit the offset field, and a downward step below zero wraps the full address. The bench uses the default adder variant, which adds the inverted offset with a carry-in. Through it the subtract path and its wraparound are checked on the same carry chain as the add path.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

   localparam int unsigned WORD_W = 32;

   typedef enum logic [1:0] {
      IDX_PRE    = 2'b00,
      IDX_PRE_WB = 2'b01,
      IDX_POST   = 2'b10,
      IDX_RSVD   = 2'b11
   } idx_mode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } xfer_size_e;

endpackage

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
   import ldst_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned OFF_W       = 12,
   parameter int unsigned ADDER_STYLE = 1
) (
   input  logic              valid_i,
   input  idx_mode_e         mode_i,
   input  logic              up_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFF_W-1:0]  off_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wb_en_o,
   output logic [ADDR_W-1:0] wb_val_o
);

   logic [ADDR_W-1:0] off_ext;
   logic [ADDR_W-1:0] sum;

   assign off_ext = ADDR_W'(off_i);

   generate
      if (ADDER_STYLE == 0) begin : g_mux_adder
         // two carry chains, result picked after
         assign sum = up_i ? (base_i + off_ext) : (base_i - off_ext);
      end else begin : g_inv_adder
         // one carry chain, operand inverted with carry-in for subtract
         logic [ADDR_W-1:0] opnd;
         logic [ADDR_W-1:0] cin;
         assign opnd = up_i ? off_ext : ~off_ext;
         assign cin  = {{(ADDR_W-1){1'b0}}, ~up_i};
         assign sum  = base_i + opnd + cin;
      end
   endgenerate

   always_comb begin
      addr_o   = sum;
      wb_en_o  = 1'b0;
      wb_val_o = sum;
      case (mode_i)
         IDX_PRE_WB: wb_en_o = valid_i;
         IDX_POST: begin
            addr_o  = base_i;
            wb_en_o = valid_i;
         end
         default: wb_en_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/ldst_store_steer.sv
module ldst_store_steer
   import ldst_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANES  = DATA_W / 8,
   parameter int unsigned LANE_W = $clog2(LANES)
) (
   input  xfer_size_e          size_i,
   input  logic [LANE_W-1:0]   lane_i,
   input  logic [WORD_W-1:0]   data_i,
   output logic [LANES-1:0]    be_o,
   output logic [DATA_W-1:0]   wdata_o
);

   logic [LANE_W-1:0] half_idx;
   logic [LANE_W-1:0] word_idx;

   assign half_idx = lane_i >> 1;
   assign word_idx = lane_i >> 2;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         localparam logic [LANE_W-1:0] LN_B = LANE_W'(g);
         localparam logic [LANE_W-1:0] LN_H = LANE_W'(g / 2);
         localparam logic [LANE_W-1:0] LN_W = LANE_W'(g / 4);
         always_comb begin
            case (size_i)
               SZ_BYTE: begin
                  be_o[g]          = (lane_i == LN_B);
                  wdata_o[g*8 +: 8] = data_i[7:0];
               end
               SZ_HALF: begin
                  be_o[g]          = (half_idx == LN_H);
                  wdata_o[g*8 +: 8] = data_i[(g%2)*8 +: 8];
               end
               default: begin
                  be_o[g]          = (word_idx == LN_W);
                  wdata_o[g*8 +: 8] = data_i[(g%4)*8 +: 8];
               end
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/ldst_load_fmt.sv
module ldst_load_fmt
   import ldst_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANES  = DATA_W / 8,
   parameter int unsigned LANE_W = $clog2(LANES)
) (
   input  xfer_size_e        size_i,
   input  logic              sign_i,
   input  logic [LANE_W-1:0] lane_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [WORD_W-1:0] data_o
);

   logic [LANE_W-1:0] half_idx;
   logic [LANE_W-1:0] word_idx;
   logic [7:0]        b_pick;
   logic [15:0]       h_pick;
   logic [31:0]       w_pick;

   assign half_idx = lane_i >> 1;
   assign word_idx = lane_i >> 2;
   assign b_pick   = rdata_i[{lane_i, 3'b000} +: 8];
   assign h_pick   = rdata_i[{half_idx, 4'b0000} +: 16];
   assign w_pick   = rdata_i[{word_idx, 5'b00000} +: 32];

   always_comb begin
      case (size_i)
         SZ_BYTE: data_o = {{24{sign_i & b_pick[7]}}, b_pick};
         SZ_HALF: data_o = {{16{sign_i & h_pick[15]}}, h_pick};
         default: data_o = w_pick;
      endcase
   end

endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
   import ldst_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned OFF_W       = 12,
   parameter int unsigned ADDER_STYLE = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_load,
   input  logic [1:0]            idx_mode,
   input  logic                  offset_up,
   input  logic [1:0]            xfer_size,
   input  logic                  load_signed,
   input  logic [ADDR_W-1:0]     base_val,
   input  logic [OFF_W-1:0]      offset_val,
   input  logic [31:0]           store_data,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [DATA_W/8-1:0]   mem_be,
   output logic [DATA_W-1:0]     mem_wdata,
   input  logic [DATA_W-1:0]     mem_rdata,
   output logic                  wb_en,
   output logic [ADDR_W-1:0]     wb_value,
   output logic                  ld_valid,
   output logic [31:0]           ld_data
);

   localparam int unsigned LANES  = DATA_W / 8;
   localparam int unsigned LANE_W = $clog2(LANES);

   generate
      if (DATA_W < WORD_W || (DATA_W % WORD_W) != 0) begin : g_bad_data_w
         $error("ldst_agu: DATA_W must be a multiple of 32");
      end
      if (OFF_W < 1 || OFF_W > ADDR_W) begin : g_bad_off_w
         $error("ldst_agu: OFF_W must lie in 1..ADDR_W");
      end
      if (ADDR_W < LANE_W + 1) begin : g_bad_addr_w
         $error("ldst_agu: ADDR_W too narrow for the lane index");
      end
      if (ADDER_STYLE > 1) begin : g_bad_style
         $error("ldst_agu: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   idx_mode_e         mode_c;
   xfer_size_e        size_c;
   logic [LANE_W-1:0] lane_c;

   assign mode_c = idx_mode_e'(idx_mode);
   assign size_c = xfer_size_e'(xfer_size);
   assign lane_c = mem_addr[LANE_W-1:0];

   ldst_addr_gen #(
      .ADDR_W      (ADDR_W),
      .OFF_W       (OFF_W),
      .ADDER_STYLE (ADDER_STYLE)
   ) u_addr_gen (
      .valid_i  (req_valid),
      .mode_i   (mode_c),
      .up_i     (offset_up),
      .base_i   (base_val),
      .off_i    (offset_val),
      .addr_o   (mem_addr),
      .wb_en_o  (wb_en),
      .wb_val_o (wb_value)
   );

   ldst_store_steer #(
      .DATA_W (DATA_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_store_steer (
      .size_i  (size_c),
      .lane_i  (lane_c),
      .data_i  (store_data),
      .be_o    (mem_be),
      .wdata_o (mem_wdata)
   );

   assign mem_req = req_valid;
   assign mem_we  = req_valid & ~req_load;

   // load context held across the memory's read latency
   logic              pend_q;
   xfer_size_e        size_q;
   logic              sign_q;
   logic [LANE_W-1:0] lane_q;
   logic [31:0]       fmt_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         size_q <= SZ_WORD;
         sign_q <= 1'b0;
         lane_q <= '0;
      end else begin
         pend_q <= req_valid & req_load;
         if (req_valid && req_load) begin
            size_q <= size_c;
            sign_q <= load_signed;
            lane_q <= lane_c;
         end
      end
   end

   ldst_load_fmt #(
      .DATA_W (DATA_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_load_fmt (
      .size_i  (size_q),
      .sign_i  (sign_q),
      .lane_i  (lane_q),
      .rdata_i (mem_rdata),
      .data_o  (fmt_data)
   );

   assign ld_valid = pend_q;
   assign ld_data  = pend_q ? fmt_data : 32'h0;

endmodule

// File: rtl/ldst_agu_chk.sv
module ldst_agu_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_load,
   input logic [1:0]          idx_mode,
   input logic [1:0]          xfer_size,
   input logic [ADDR_W-1:0]   base_val,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic [DATA_W/8-1:0] mem_be,
   input logic                wb_en,
   input logic                ld_valid
);

   AST_PRE_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && idx_mode[1] == idx_mode[0]) |-> !wb_en); // R1

   AST_WB_MODE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && idx_mode == 2'b01) |-> wb_en); // R2

   AST_POST_USES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && idx_mode == 2'b10) |-> (mem_addr == base_val && wb_en)); // R3

   AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && xfer_size == 2'b00) |-> $countones(mem_be) == 1); // R5

   AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && xfer_size == 2'b01) |-> $countones(mem_be) == 2); // R6

   AST_LOAD_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_load) |=> ld_valid); // R8

   AST_NO_STRAY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_load) |=> !ld_valid); // R11

   AST_WB_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !wb_en); // R11

endmodule

bind ldst_agu ldst_agu_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_load  (req_load),
   .idx_mode  (idx_mode),
   .xfer_size (xfer_size),
   .base_val  (base_val),
   .mem_addr  (mem_addr),
   .mem_be    (mem_be),
   .wb_en     (wb_en),
   .ld_valid  (ld_valid)
);

// File: tb/ldst_agu_bench.sv
`timescale 1ns/1ps
module ldst_agu_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_load = 1'b0;
   logic [1:0]  idx_mode = 2'b00;
   logic        offset_up = 1'b1;
   logic [1:0]  xfer_size = 2'b10;
   logic        load_signed = 1'b0;
   logic [31:0] base_val = '0;
   logic [11:0] offset_val = '0;
   logic [31:0] store_data = '0;
   logic        mem_req, mem_we, wb_en, ld_valid;
   logic [31:0] mem_addr, mem_wdata, wb_value, ld_data;
   logic [3:0]  mem_be;
   logic [31:0] mem_rdata = '0;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   logic [31:0] ram [0:63];
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #2.5 clk = ~clk;

   ldst_agu u_ldst_agu (
      .clk, .rst_n, .req_valid, .req_load, .idx_mode, .offset_up, .xfer_size,
      .load_signed, .base_val, .offset_val, .store_data, .mem_req, .mem_we,
      .mem_addr, .mem_be, .mem_wdata, .mem_rdata, .wb_en, .wb_value,
      .ld_valid, .ld_data
   );

   // synchronous memory, one-cycle read
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            for (int k = 0; k < 4; k++)
               if (mem_be[k]) ram[mem_addr[7:2]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
         end else begin
            mem_rdata <= ram[mem_addr[7:2]];
         end
      end
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic logic [3:0] x_be(input logic [1:0] sz, input logic [1:0] a);
      case (sz)
         2'b00:   x_be = 4'b0001 << a;
         2'b01:   x_be = a[1] ? 4'b1100 : 4'b0011;
         default: x_be = 4'b1111;
      endcase
   endfunction

   function automatic logic [31:0] x_wd(input logic [1:0] sz, input logic [31:0] d);
      case (sz)
         2'b00:   x_wd = {4{d[7:0]}};
         2'b01:   x_wd = {2{d[15:0]}};
         default: x_wd = d;
      endcase
   endfunction

   function automatic logic [31:0] x_ld(input logic [1:0] sz, input logic sg,
                                        input logic [31:0] w, input logic [1:0] a);
      logic [7:0]  bt;
      logic [15:0] hw;
      case (a)
         2'd0: bt = w[7:0];
         2'd1: bt = w[15:8];
         2'd2: bt = w[23:16];
         default: bt = w[31:24];
      endcase
      hw = a[1] ? w[31:16] : w[15:0];
      case (sz)
         2'b00:   x_ld = (sg && bt[7])  ? {24'hFFFFFF, bt} : {24'h0, bt};
         2'b01:   x_ld = (sg && hw[15]) ? {16'hFFFF, hw}   : {16'h0, hw};
         default: x_ld = w;
      endcase
   endfunction

   // driver: applies one request, checks same-cycle outputs, queues load result
   task automatic req(input string rq, input bit ld, input logic [1:0] md, input bit up,
                      input logic [1:0] sz, input bit sg, input logic [31:0] bs,
                      input logic [11:0] of, input logic [31:0] sd);
      logic [31:0] sum, ea;
      bit          wbx;
      @(negedge clk);
      req_valid = 1'b1; req_load = ld; idx_mode = md; offset_up = up;
      xfer_size = sz; load_signed = sg; base_val = bs; offset_val = of; store_data = sd;
      #1;
      sum = up ? bs + {20'h0, of} : bs - {20'h0, of};
      ea  = (md == 2'b10) ? bs : sum;
      wbx = (md == 2'b01) || (md == 2'b10);
      chk({rq, " addr"}, mem_addr, ea);
      chk({rq, " wb_en"}, {31'h0, wb_en}, {31'h0, wbx});
      if (wbx) chk({rq, " wb_value"}, wb_value, sum);
      chk("R11 mem_req", {31'h0, mem_req}, 32'h1);
      chk("R11 mem_we", {31'h0, mem_we}, {31'h0, ~ld});
      chk({rq, " be"}, {28'h0, mem_be}, {28'h0, x_be(sz, ea[1:0])});
      if (!ld) chk({rq, " wdata"}, mem_wdata, x_wd(sz, sd));
      else begin
         exp_q.push_back(x_ld(sz, sg, ram[ea[7:2]], ea[1:0]));
         tag_q.push_back(rq);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk("R11 idle mem_req", {31'h0, mem_req}, 32'h0);
      chk("R11 idle wb_en", {31'h0, wb_en}, 32'h0);
   endtask

   // monitor: scoreboard compare of load results
   always @(negedge clk) begin
      if (rst_n && ld_valid) begin
         if (exp_q.size() == 0) begin
            n_vec++; n_bad++;
            $display("FAIL R11 unexpected ld_valid actual=1 expected=0");
         end else begin
            chk({tag_q.pop_front(), " ld_data"}, ld_data, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) ram[i] = 32'h0;
      repeat (3) @(negedge clk);
      chk("R12 ld_valid in reset", {31'h0, ld_valid}, 32'h0);
      chk("R12 ld_data in reset", ld_data, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 ld_valid after reset", {31'h0, ld_valid}, 32'h0);
      chk("R11 wb_en idle", {31'h0, wb_en}, 32'h0);

      // words around 0x00090000
      req("R7 R1", 0, 2'b00, 1, 2'b10, 0, 32'h0009_0000, 12'd0, 32'h0101_0101);
      req("R7 R2", 0, 2'b01, 1, 2'b10, 0, 32'h0009_0000, 12'd4, 32'h0202_0202);
      req("R2 R10", 1, 2'b01, 1, 2'b10, 0, 32'h0009_0000, 12'd4, 32'h0);
      req("R1 R10", 1, 2'b00, 1, 2'b10, 1, 32'h0009_0000, 12'd4, 32'h0);
      req("R3 R10", 1, 2'b10, 1, 2'b10, 0, 32'h0009_0000, 12'd4, 32'h0);
      idle();

      // offset add/subtract, wraparound
      req("R4 R1", 0, 2'b00, 1, 2'b10, 0, 32'h0000_2000, 12'd16, 32'hCAFE_F00D);
      req("R4 R2", 1, 2'b01, 0, 2'b10, 0, 32'h0000_2014, 12'd4, 32'h0);
      req("R4 R3", 1, 2'b10, 0, 2'b10, 0, 32'h0000_2010, 12'h010, 32'h0);
      req("R4 wrap", 1, 2'b00, 0, 2'b10, 0, 32'h0000_0002, 12'd4, 32'h0);

      // byte stores on every lane, then loads both ways
      req("R5 lane0", 0, 2'b00, 1, 2'b00, 0, 32'h0000_2010, 12'd0, 32'h1234_5680);
      req("R5 lane1", 0, 2'b00, 1, 2'b00, 0, 32'h0000_2010, 12'd1, 32'h0000_007F);
      req("R5 lane2", 0, 2'b00, 1, 2'b00, 0, 32'h0000_2010, 12'd2, 32'hAAAA_AAFF);
      req("R5 lane3", 0, 2'b00, 1, 2'b00, 0, 32'h0000_2010, 12'd3, 32'h0000_0001);
      idle();
      for (int ln = 0; ln < 4; ln++) begin
         req("R8 unsigned", 1, 2'b00, 1, 2'b00, 0, 32'h0000_2010, 12'(ln), 32'h0);
         req("R8 signed", 1, 2'b00, 1, 2'b00, 1, 32'h0000_2010, 12'(ln), 32'h0);
      end
      idle();

      // halfwords
      req("R6 upper", 0, 2'b00, 1, 2'b01, 0, 32'h0000_2010, 12'd2, 32'h5555_8001);
      req("R6 lower", 0, 2'b00, 1, 2'b01, 0, 32'h0000_2010, 12'd0, 32'h0000_1234);
      req("R9 hi unsigned", 1, 2'b00, 1, 2'b01, 0, 32'h0000_2010, 12'd2, 32'h0);
      req("R9 hi signed", 1, 2'b00, 1, 2'b01, 1, 32'h0000_2010, 12'd2, 32'h0);
      req("R9 lo signed", 1, 2'b00, 1, 2'b01, 1, 32'h0000_2010, 12'd0, 32'h0);
      req("R9 lo unsigned", 1, 2'b10, 1, 2'b01, 0, 32'h0000_2010, 12'd0, 32'h0);

      // unused encodings
      req("R1 mode11", 1, 2'b11, 1, 2'b10, 0, 32'h0000_200C, 12'd4, 32'h0);
      req("R7 size11", 0, 2'b11, 1, 2'b11, 0, 32'h0000_2020, 12'd0, 32'h1357_9BDF);
      req("R10 size11", 1, 2'b00, 1, 2'b11, 1, 32'h0000_2020, 12'd0, 32'h0);
      idle();
      idle();
      idle();

      if (exp_q.size() != 0) begin
         n_vec++; n_bad++;
         $display("FAIL R11 missing ld_valid actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule